// File: doc/BRIEF.md
# Via Test Report Stream Decoder

This block is the receiving end of the serial fault report that a die's through-silicon-via test logic sends to a tester or a built-in self-test engine. Bits arrive one per cycle when a valid qualifier is high. A frame-start pulse arms the decoder. The first two bits of the frame carry a fault condition. A clean die or a bad die is classified at once, and that ends the frame.

A die that may still be repaired sends more fields. It sends a count of faulty groups. Then it sends that many records, and each record is a group address followed by the result bits of that group. Every field is sent most significant bit first. Each finished record is presented on parallel outputs for the repair logic, together with a one-cycle strobe.

A one-cycle completion pulse marks the end of a well-formed frame, and the final classification is held on an output after it. Malformed frames raise a one-cycle error pulse instead.

Top module: `rsd_decoder`

## Requirements
- R1: After reset the decoder is idle (`busy`=0), `rec_valid`, `done` and `err` are 0, and `verdict` is 2'b00.
- R2: A condition field of 2'b00 ends the frame: `done` pulses once, `verdict` becomes 2'b00, and no record is emitted.
- R3: A condition field of 2'b11 ends the frame: `done` pulses once, `verdict` becomes 2'b11, and no record is emitted.
- R4: A condition field of 2'b10 raises `err` for one cycle, gives no `done` pulse, and returns the decoder to idle. `done` and `err` are never high together.
- R5: A condition field of 2'b01 is followed by a CNT_W-bit record count. A count of zero raises `err` and returns the decoder to idle.
- R6: Each record is an ADDR_W-bit address and then RES_W result bits. Both are sent MSB first. `rec_valid` pulses for one cycle after the last result bit. `rec_addr` and `rec_res` hold their values until the next pulse.
- R7: After the number of records given by the count, `done` pulses in the same cycle as the last `rec_valid`, and `verdict` becomes 2'b01.
- R8: Cycles with `bit_vld` low are not sampled, whatever `bit_dat` carries.
- R9: Bits that arrive after a frame has ended are ignored until the next `frame_start`. A `frame_start` in the middle of a frame drops the partial frame and starts a new one.
- R10: `verdict` changes only on a `done` pulse. An error frame leaves it unchanged.
- R11: Each output registers the bit sampled at a clock edge and changes at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Arms the decoder for a new frame; has priority over a bit in the same cycle |
| bit_vld | input | 1 | Qualifies `bit_dat` |
| bit_dat | input | 1 | Serial report bit |
| busy | output | 1 | High while a frame is being parsed |
| rec_valid | output | 1 | One-cycle strobe per completed record |
| rec_addr | output | ADDR_W | Group address of the last record |
| rec_res | output | RES_W | Result bits of the last record |
| done | output | 1 | One-cycle pulse at the end of a well-formed frame |
| err | output | 1 | One-cycle pulse on a malformed frame |
| verdict | output | 2 | Last classification: 00 clean, 01 repairable, 11 bad |

## Verification
A wrong field boundary or a wrong bit index moves every later field. The damage shows at the first `rec_valid`, which carries a shifted address or shifted result bits, no more than one record after the fault. A wrong record counter shows when `done` arrives, either a record early or late, or when a record is emitted after `done`. A state that fails to return to idle shows as strobes produced by trailing bits. A state that fails to leave idle shows as a missing classification within the two condition bits.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COND,
        ST_CNT,
        ST_ADDR,
        ST_RES
    } rsd_state_e;

    typedef enum logic [1:0] {
        FC_CLEAN   = 2'b00,
        FC_REPAIR  = 2'b01,
        FC_ILLEGAL = 2'b10,
        FC_BAD     = 2'b11
    } fc_e;

    localparam int COND_BITS = 2;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rsd_field_acc.sv
// Shifts one field in MSB first and flags the bit that completes it.
module rsd_field_acc #(
    parameter int SH_W  = 5,
    parameter int LEN_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              shift,
    input  logic              bit_i,
    input  logic [LEN_W-1:0]  len,
    output logic              fld_done,
    output logic [SH_W-1:0]   fld_val
);
    logic [SH_W-1:0]  sh_q;
    logic [LEN_W-1:0] idx_q;

    always_comb begin
        fld_done = shift && (idx_q == len - 1'b1);
        fld_val  = {sh_q[SH_W-2:0], bit_i};
    end

    always_ff @(posedge clk) begin
        if (rst || clr || fld_done) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (shift) begin
            sh_q  <= {sh_q[SH_W-2:0], bit_i};
            idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/rsd_rec_cnt.sv
// Counts down the records still expected in a frame.
module rsd_rec_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] rem_q;

    assign last = (rem_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)       rem_q <= '0;
        else if (load) rem_q <= load_val;
        else if (dec)  rem_q <= rem_q - 1'b1;
    end
endmodule

// File: rtl/rsd_decoder.sv
module rsd_decoder
    import rsd_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int ADDR_W = 3,
    parameter int RES_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              bit_vld,
    input  logic              bit_dat,
    output logic              busy,
    output logic              rec_valid,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [RES_W-1:0]  rec_res,
    output logic              done,
    output logic              err,
    output logic [1:0]        verdict
);
    localparam int SH_W  = max_of(max_of(COND_BITS, CNT_W), max_of(max_of(ADDR_W, RES_W), 2));
    localparam int LEN_W = $clog2(SH_W + 1);

    rsd_state_e        state_q;
    logic              take;
    logic [LEN_W-1:0]  fld_len;
    logic              fld_done;
    logic [SH_W-1:0]   fld_val;
    logic              cnt_load;
    logic              cnt_dec;
    logic              cnt_last;
    logic [ADDR_W-1:0] addr_q;
    fc_e               fc;

    always_comb begin
        take = bit_vld && !frame_start && (state_q != ST_IDLE);
        unique case (state_q)
            ST_COND: fld_len = LEN_W'(COND_BITS);
            ST_CNT:  fld_len = LEN_W'(CNT_W);
            ST_ADDR: fld_len = LEN_W'(ADDR_W);
            ST_RES:  fld_len = LEN_W'(RES_W);
            default: fld_len = LEN_W'(1);
        endcase
        fc       = fc_e'(fld_val[1:0]);
        cnt_load = fld_done && (state_q == ST_CNT);
        cnt_dec  = fld_done && (state_q == ST_RES);
        busy     = (state_q != ST_IDLE);
    end

    rsd_field_acc #(.SH_W(SH_W), .LEN_W(LEN_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .clr      (frame_start),
        .shift    (take),
        .bit_i    (bit_dat),
        .len      (fld_len),
        .fld_done (fld_done),
        .fld_val  (fld_val)
    );

    rsd_rec_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (fld_val[CNT_W-1:0]),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            rec_valid <= 1'b0;
            rec_addr  <= '0;
            rec_res   <= '0;
            addr_q    <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
            verdict   <= FC_CLEAN;
        end else begin
            rec_valid <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
            if (frame_start) begin
                state_q <= ST_COND;
            end else if (fld_done) begin
                unique case (state_q)
                    ST_COND: begin
                        unique case (fc)
                            FC_CLEAN, FC_BAD: begin
                                done    <= 1'b1;
                                verdict <= fc;
                                state_q <= ST_IDLE;
                            end
                            FC_ILLEGAL: begin
                                err     <= 1'b1;
                                state_q <= ST_IDLE;
                            end
                            default: state_q <= ST_CNT;
                        endcase
                    end
                    ST_CNT: begin
                        if (fld_val[CNT_W-1:0] == '0) begin
                            err     <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_ADDR;
                        end
                    end
                    ST_ADDR: begin
                        addr_q  <= fld_val[ADDR_W-1:0];
                        state_q <= ST_RES;
                    end
                    ST_RES: begin
                        rec_valid <= 1'b1;
                        rec_addr  <= addr_q;
                        rec_res   <= fld_val[RES_W-1:0];
                        if (cnt_last) begin
                            done    <= 1'b1;
                            verdict <= FC_REPAIR;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_ADDR;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rsd_chk.sv
module rsd_chk #(
    parameter int ADDR_W = 3,
    parameter int RES_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic              bit_vld,
    input logic              busy,
    input logic              rec_valid,
    input logic [ADDR_W-1:0] rec_addr,
    input logic [RES_W-1:0]  rec_res,
    input logic              done,
    input logic              err,
    input logic [1:0]        verdict
);
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    p_rec_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !rec_valid |-> ($stable(rec_addr) && $stable(rec_res)));

    p_rec_src_r8: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> $past(bit_vld));

    p_done_src_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(bit_vld) && !$past(frame_start)));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(busy) |-> (!rec_valid && !done && !err));

    p_verdict_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(verdict));
endmodule

bind rsd_decoder rsd_chk #(.ADDR_W(ADDR_W), .RES_W(RES_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .bit_vld     (bit_vld),
    .busy        (busy),
    .rec_valid   (rec_valid),
    .rec_addr    (rec_addr),
    .rec_res     (rec_res),
    .done        (done),
    .err         (err),
    .verdict     (verdict)
);

// File: tb/test_rsd_decoder.sv
`timescale 1ns/1ps
module test_rsd_decoder;
    localparam int CNT_W  = 4;
    localparam int ADDR_W = 3;
    localparam int RES_W  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic bit_vld = 1'b0;
    logic bit_dat = 1'b0;
    logic busy, rec_valid, done, err;
    logic [ADDR_W-1:0] rec_addr;
    logic [RES_W-1:0]  rec_res;
    logic [1:0]        verdict;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int got_n, got_done, got_err;
    bit done_with_rec;
    int got_addr [0:63];
    int got_res  [0:63];
    int exp_addr [0:63];
    int exp_res  [0:63];

    always #4 clk = ~clk;

    rsd_decoder #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .RES_W(RES_W)) i_rsd_decoder (
        .clk(clk), .rst(rst), .frame_start(frame_start), .bit_vld(bit_vld),
        .bit_dat(bit_dat), .busy(busy), .rec_valid(rec_valid), .rec_addr(rec_addr),
        .rec_res(rec_res), .done(done), .err(err), .verdict(verdict)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rec_valid) begin
                if (got_n < 64) begin
                    got_addr[got_n] = int'(rec_addr);
                    got_res[got_n]  = int'(rec_res);
                end
                got_n++;
            end
            if (done) begin
                got_done++;
                done_with_rec = rec_valid;
            end
            if (err) got_err++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic idle(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            bit_vld = 1'b0;
            bit_dat = 1'($urandom);
            @(negedge clk);
        end
    endtask

    task automatic push(input bit b, input bit gaps);
        if (gaps) idle(int'($urandom % 3));
        bit_vld = 1'b1;
        bit_dat = b;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic send_field(input int val, input int w, input bit gaps);
        for (int i = w - 1; i >= 0; i--) push(1'((val >> i) & 1), gaps);
    endtask

    task automatic pulse_start();
        frame_start = 1'b1;
        bit_vld = 1'b1;          // ignored: start has priority
        bit_dat = 1'($urandom);
        @(negedge clk);
        frame_start = 1'b0;
        bit_vld = 1'b0;
    endtask

    function automatic int exp_done_n(input int cond, input int n);
        return (cond == 0 || cond == 3 || (cond == 1 && n > 0)) ? 1 : 0;
    endfunction

    function automatic int exp_err_n(input int cond, input int n);
        return (cond == 2 || (cond == 1 && n == 0)) ? 1 : 0;
    endfunction

    task automatic run_frame(input int cond, input int n, input bit gaps, input bit tail);
        int prev_v;
        int exp_recs;
        bit recs_ok;
        prev_v = int'(verdict);
        pulse_start();
        got_n = 0; got_done = 0; got_err = 0; done_with_rec = 0;
        send_field(cond, 2, gaps);
        if (cond == 1) begin
            send_field(n, CNT_W, gaps);
            for (int r = 0; r < n; r++) begin
                exp_addr[r] = int'($urandom % (1 << ADDR_W));
                exp_res[r]  = int'($urandom % (1 << RES_W));
                send_field(exp_addr[r], ADDR_W, gaps);
                send_field(exp_res[r], RES_W, gaps);
            end
        end
        if (tail) send_field(int'($urandom), 12, gaps);  // R9: trailing bits
        idle(2);
        exp_recs = (cond == 1) ? n : 0;
        check(got_done == exp_done_n(cond, n), "R2/R3/R7 done count", got_done, exp_done_n(cond, n));
        check(got_err == exp_err_n(cond, n), "R4/R5 err count", got_err, exp_err_n(cond, n));
        check(got_n == exp_recs, "R6/R9 record count", got_n, exp_recs);
        recs_ok = 1;
        for (int r = 0; r < exp_recs && r < got_n; r++)
            if (got_addr[r] != exp_addr[r] || got_res[r] != exp_res[r]) recs_ok = 0;
        check(recs_ok, "R6 record contents", int'(recs_ok), 1);
        if (exp_done_n(cond, n) == 1)
            check(int'(verdict) == cond, "R2/R3/R7 verdict", int'(verdict), cond);
        else
            check(int'(verdict) == prev_v, "R10 verdict held", int'(verdict), prev_v);
        if (cond == 1 && n > 0)
            check(done_with_rec, "R7 done with last record", int'(done_with_rec), 1);
        check(!busy, "R9 idle after frame", int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1d5c));
        got_n = 0; got_done = 0; got_err = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !rec_valid && !done && !err, "R1 outputs idle", int'({busy, rec_valid, done, err}), 0);
        check(verdict == 2'b00, "R1 verdict", int'(verdict), 0);
        // R8 bits without start or qualifier do nothing
        idle(5);
        check(!busy, "R8 no start stays idle", int'(busy), 0);

        run_frame(3, 0, 0, 1);   // R3 bad, tail ignored
        run_frame(2, 0, 1, 0);   // R4 illegal, verdict held (R10)
        run_frame(0, 0, 0, 1);   // R2 clean
        run_frame(1, 0, 0, 0);   // R5 zero count
        run_frame(1, 1, 0, 1);   // R7 single record
        run_frame(1, 15, 1, 1);  // R6 max count with gaps (R8)

        // R9 restart in mid-frame
        pulse_start();
        send_field(1, 2, 0);
        send_field(3, CNT_W, 0);
        send_field(5, ADDR_W, 0);
        send_field(9, RES_W, 0);
        send_field(2, 2, 0);     // partial address
        run_frame(1, 2, 0, 0);

        // R11 edge timing: done visible right after the edge sampling the last bit
        pulse_start();
        push(1'b1, 0);
        bit_vld = 1'b1; bit_dat = 1'b1;
        @(posedge clk);
        #1;
        check(done == 1'b1, "R11 done at sampling edge", int'(done), 1);
        @(negedge clk);
        bit_vld = 1'b0;
        idle(2);

        for (int t = 0; t < 60; t++) begin
            int c;
            c = int'($urandom % 4);
            run_frame(c, int'($urandom % 16), 1'($urandom), 1'($urandom));
        end
        finish_run();
    end
endmodule